// File: doc/BRIEF.md
# Symbol Parity Tracker

This block takes one symbol per clock from a three-letter alphabet, carried as a 2-bit code with a valid strobe. It keeps two parity bits, one for the count of "alpha" symbols seen since reset and one for the count of "beta" symbols. The third letter, "gamma", is a filler that changes nothing. Only the two parities are kept; the block never holds the totals.

The four combined parity conditions are held in a 2-bit state register with a fixed encoding. That encoding is not the raw pair of parity bits. The block is a Moore machine. Its registered one-bit match output is high exactly when the alpha parity is even and the beta parity is odd. Code 3 is not a legal symbol. It is treated as filler, and it raises a sticky error flag that only reset clears.

Top module: `sym_parity_top`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), the state is even-alpha/even-beta, match_o is 0 and err_o is 0.
- R2: A valid alpha symbol (sym_i = 2'b00) toggles the alpha parity. A valid beta symbol (sym_i = 2'b01) toggles the beta parity.
- R3: A valid gamma symbol (sym_i = 2'b10) leaves both parities unchanged, so match_o keeps its value.
- R4: When sym_vld_i is low, both parities and err_o hold, whatever value sym_i carries.
- R5: match_o is 1 only in the even-alpha/odd-beta state. It is registered and reflects the symbols accepted up to and including the previous clock edge.
- R6: A valid illegal code (sym_i = 2'b11) leaves both parities unchanged.
- R7: A valid illegal code sets err_o at the next clock edge. err_o then stays 1 until reset.
- R8: The state register uses this encoding: even/even = 00, even-alpha/odd-beta = 01, odd/odd = 10, odd-alpha/even-beta = 11. It moves only between states that differ in exactly one parity, and it stays put on gamma or an illegal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld_i | input | 1 | Symbol valid strobe |
| sym_i | input | 2 | Symbol code: 00 alpha, 01 beta, 10 gamma, 11 illegal |
| match_o | output | 1 | Registered: alpha count even and beta count odd |
| err_o | output | 1 | Sticky flag: an illegal code was accepted |

## Verification
The hardest case to reach from the ports is the odd-alpha/odd-beta state. Its output looks exactly like two other states, so a stuck or mis-encoded transition into it only shows up later, when a further symbol is supposed to leave it. The bench drives long mixed streams with gamma symbols, illegal codes and idle cycles interleaved, and checks match_o after each accepted symbol. Any wrong turn through that state therefore surfaces at the next state with a different output. A separate scenario sends an illegal code while the state is in the single state where match_o is high. A wrong transition would then show at once, alongside the error flag.

// File: rtl/sym_parity_pkg.sv
package sym_parity_pkg;
  localparam int SYM_W = 2;
  localparam int ST_W  = 2;

  typedef enum logic [SYM_W-1:0] {
    SYM_ALPHA = 2'b00,
    SYM_BETA  = 2'b01,
    SYM_GAMMA = 2'b10,
    SYM_BAD   = 2'b11
  } sym_e;

  typedef enum logic [ST_W-1:0] {
    ST_EE = 2'b00,
    ST_EO = 2'b01,
    ST_OO = 2'b10,
    ST_OE = 2'b11
  } par_st_e;
endpackage

// File: rtl/sym_decode.sv
module sym_decode
  import sym_parity_pkg::*;
#(
  parameter int SW = SYM_W
) (
  input  logic          vld_i,
  input  logic [SW-1:0] sym_i,
  output logic          flip_a_o,
  output logic          flip_b_o,
  output logic          bad_o
);
  always_comb begin
    flip_a_o = 1'b0;
    flip_b_o = 1'b0;
    bad_o    = 1'b0;
    if (vld_i) begin
      case (sym_e'(sym_i))
        SYM_ALPHA: flip_a_o = 1'b1;
        SYM_BETA:  flip_b_o = 1'b1;
        SYM_BAD:   bad_o    = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/parity_fsm.sv
module parity_fsm
  import sym_parity_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    flip_a_i,
  input  logic    flip_b_i,
  output par_st_e st_o
);
  par_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_EE: if (flip_a_i) st_d = ST_OE; else if (flip_b_i) st_d = ST_EO;
      ST_EO: if (flip_a_i) st_d = ST_OO; else if (flip_b_i) st_d = ST_EE;
      ST_OO: if (flip_a_i) st_d = ST_EO; else if (flip_b_i) st_d = ST_OE;
      ST_OE: if (flip_a_i) st_d = ST_EE; else if (flip_b_i) st_d = ST_OO;
      default: st_d = ST_EE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_EE;
    else     st_q <= st_d;
  end

  assign st_o = st_q;

  // R8
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    (flip_a_i || flip_b_i) |=> ($countones(st_q ^ $past(st_q)) >= 1));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flip_a_i && !flip_b_i) |=> $stable(st_q));
endmodule

// File: rtl/sym_parity_top.sv
module sym_parity_top
  import sym_parity_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_vld_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             match_o,
  output logic             err_o
);
  logic    flip_a, flip_b, bad;
  par_st_e st;
  logic    match_q, err_q;

  sym_decode #(.SW(SYM_W)) u_dec (
    .vld_i(sym_vld_i), .sym_i(sym_i),
    .flip_a_o(flip_a), .flip_b_o(flip_b), .bad_o(bad)
  );

  parity_fsm u_fsm (
    .clk(clk), .rst(rst), .flip_a_i(flip_a), .flip_b_i(flip_b), .st_o(st)
  );

  // Output register follows the state register by one edge; to keep the
  // Moore output aligned with the accepted symbols it is fed from the
  // next-state view: decode the state the FSM is moving to.
  function automatic logic eo_next(input par_st_e s, input logic fa, input logic fb);
    logic pa, pb;
    pa = (s == ST_OO) || (s == ST_OE);
    pb = (s == ST_EO) || (s == ST_OO);
    pa = pa ^ fa;
    pb = pb ^ fb;
    return !pa && pb;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      match_q <= eo_next(st, flip_a, flip_b);
      err_q   <= err_q | bad;
    end
  end

  assign match_o = match_q;
  assign err_o   = err_q;

  // R5
  match_state_chk: assert property (@(posedge clk) disable iff (rst)
    match_o == (st == ST_EO));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_vld_i && sym_i == 2'b11) |=> err_o);
  // R4
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_vld_i |=> ($stable(match_o) && $stable(err_o)));
endmodule

// File: tb/test_sym_parity_top.sv
module test_sym_parity_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [1:0] sym = 2'b00;
  logic match_o, err_o;

  int n_vec = 0;
  int n_bad = 0;
  bit ref_pa = 1'b0, ref_pb = 1'b0, ref_err = 1'b0;

  always #10 clk = ~clk;

  sym_parity_top i_sym_parity_top (
    .clk(clk), .rst(rst), .sym_vld_i(vld), .sym_i(sym),
    .match_o(match_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input bit v, input logic [1:0] s, input string req);
    @(negedge clk);
    vld = v; sym = s;
    if (v) begin
      if (s == 2'b00) ref_pa = ~ref_pa;
      if (s == 2'b01) ref_pb = ~ref_pb;
      if (s == 2'b11) ref_err = 1'b1;
    end
    @(negedge clk);
    vld = 1'b0;
    chk(req, match_o, !ref_pa && ref_pb);
    chk({req, "/err"}, err_o, ref_err);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; vld = 1'b0;
    @(negedge clk); rst = 1'b0;
    ref_pa = 0; ref_pb = 0; ref_err = 0;
    chk("R1 match", match_o, 1'b0);
    chk("R1 err", err_o, 1'b0);
  endtask

  task automatic t_basic();
    send(1, 2'b01, "R2 beta"); send(1, 2'b01, "R2 beta2");
    send(1, 2'b00, "R2 alpha"); send(1, 2'b01, "R2 oo");
    send(1, 2'b00, "R8 oo->eo"); send(1, 2'b01, "R8 eo->ee");
  endtask

  task automatic t_gamma();
    send(1, 2'b01, "R2"); send(1, 2'b10, "R3 gamma");
    send(1, 2'b10, "R3 gamma2");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) send(0, 2'(i), "R4 idle");
  endtask

  task automatic t_illegal();
    send(1, 2'b11, "R6 illegal in eo");
    send(1, 2'b01, "R7 sticky"); send(1, 2'b00, "R7 sticky2");
  endtask

  task automatic t_mix();
    logic [1:0] s;
    for (int i = 0; i < 60; i++) begin
      s = 2'((i * 7 + i / 3) % 4);
      send((i % 5) != 0, s, "R5 mix");
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    t_basic(); t_gamma(); t_idle();
    do_reset();
    send(1, 2'b01, "R5 to eo");
    t_illegal();
    do_reset(); t_mix();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule